// File: doc/BRIEF.md
# Repeating Block Move and Search Sequencer

This block walks a run of bytes in memory, one byte per step. A copy operation reads the byte under a source pointer and writes it to the address held in a destination pointer. A search operation reads the byte under the source pointer and tests it against a stored reference byte. Both pointers can step up or step down, and every step takes one off a 16-bit count. Each operation has a one-shot form, which makes exactly one step. It also has a repeating form, which runs until the count reaches zero. A repeating search also stops at the first byte that equals the reference.

A single pulse on `start` loads all operands. While the work runs, the block reports `busy` and drives a synchronous byte memory port, whose read data arrives one cycle after the read request. When the operation ends, `done` pulses for one cycle. Two flags then describe the result: whether the remaining count is nonzero, and whether the last byte searched matched the reference.

Top module: `blkop_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd`, `mem_wr`, `cnt_nz` and `match` are all 0.
- R2: The `op` field uses these bits. Bit 0 sets the direction (0 = pointers step up, 1 = step down). Bit 1 sets the kind (0 = copy, 1 = search). Bit 2 selects the repeating form. A `start` while idle loads the op, `src_init`, `dst_init`, `cnt_init` and `acc`. A `start` while `busy` is high has no effect.
- R3: A copy step runs over three cycles. In the first, `mem_rd` is high with `mem_addr` equal to the source pointer. In the second, `mem_wr` is high with `mem_addr` equal to the destination pointer and `mem_wdata` equal to the byte just read. The third cycle updates the registers.
- R4: A search step reads the byte under the source pointer and never writes memory. It leaves the destination pointer unchanged.
- R5: Each step moves the source pointer by one, and a copy step also moves the destination pointer by one. Pointers step modulo 2^AW. The count goes down by one modulo 2^CW.
- R6: A one-shot form makes exactly one step, whatever the starting count, including a count of 0 or 1.
- R7: A repeating copy continues until the count reaches zero. A starting count of 0 gives 2^CW steps. At the end `cnt_nz` is 0.
- R8: A repeating search stops after the first step whose byte equals the reference, or after the step that brings the count to zero, whichever comes first. `match` is 1 after a search whose last byte equalled the reference, and 0 otherwise. `match` is 0 after any copy.
- R9: After each step, `cnt_nz` reports whether the count is nonzero.
- R10: `busy` is high from the cycle after the accepted `start` through the cycle in which `done` is high. `done` lasts one cycle and comes one cycle after the last update. For n steps, `done` rises 3n clock edges after the edge that accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted while idle) |
| op | input | 3 | {repeat, search, down} |
| src_init | input | AW | Starting source pointer |
| dst_init | input | AW | Starting destination pointer |
| cnt_init | input | CW | Starting byte count |
| acc | input | DW | Reference byte for search |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cnt_nz | output | 1 | Count nonzero after the last step |
| match | output | 1 | Last searched byte equalled the reference |
| src_ptr | output | AW | Current source pointer |
| dst_ptr | output | AW | Current destination pointer |
| count | output | CW | Current count |

## Verification
The assertions assume two things about the memory: `mem_rdata` holds the byte addressed by the previous cycle's read, and nothing outside the block changes memory while it is busy. The bench memory model gives a registered read and is rewritten only between operations, while the block is idle. The bench sweeps all eight op encodings over every starting count of a small count width. Its pointer starts force wrap-around in both directions, and its reference bytes either fall inside the search path or lie outside it. One further run pulses `start` in the middle of an operation with different operands.

// File: rtl/blkop_pkg.sv
package blkop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_READ = 3'd1,
    ST_XFER = 3'd2,
    ST_UPD  = 3'd3,
    ST_DONE = 3'd4
  } state_t;

  // op[2]=repeat, op[1]=search, op[0]=down
  typedef struct packed {
    logic rep;
    logic cmp;
    logic down;
  } op_t;
endpackage

// File: rtl/blkop_stepreg.sv
module blkop_stepreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  input  logic         down,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= load_val;
    else if (en)   q <= down ? q - ONE : q + ONE;
  end
endmodule

// File: rtl/blkop_ctrl.sv
module blkop_ctrl
  import blkop_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    op_in,
  input  logic [DW-1:0] acc_in,
  input  logic [CW-1:0] cnt_q,
  input  logic [DW-1:0] mem_rdata,
  output op_t           op_q,
  output state_t        state,
  output logic          ld,
  output logic          step_src,
  output logic          step_dst,
  output logic          step_cnt,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          busy,
  output logic          done,
  output logic          match_q,
  output logic          cnt_nz_q
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  state_t        state_d;
  logic [DW-1:0] acc_q;
  logic          last_step;

  assign ld        = (state == ST_IDLE) && start;
  assign step_src  = (state == ST_UPD);
  assign step_dst  = (state == ST_UPD) && !op_q.cmp;
  assign step_cnt  = (state == ST_UPD);
  assign last_step = !op_q.rep || (cnt_q == CNT_ONE) || (op_q.cmp && match_q);

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE: if (start) state_d = ST_READ;
      ST_READ: state_d = ST_XFER;
      ST_XFER: state_d = ST_UPD;
      ST_UPD:  state_d = last_step ? ST_DONE : ST_READ;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      op_q     <= '0;
      acc_q    <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      mem_rd   <= 1'b0;
      mem_wr   <= 1'b0;
      match_q  <= 1'b0;
      cnt_nz_q <= 1'b0;
    end else begin
      state  <= state_d;
      busy   <= (state_d != ST_IDLE);
      done   <= (state_d == ST_DONE);
      mem_rd <= (state_d == ST_READ);
      mem_wr <= (state_d == ST_XFER) && !(ld ? op_in[1] : op_q.cmp);
      if (ld) begin
        op_q    <= op_t'(op_in);
        acc_q   <= acc_in;
        match_q <= 1'b0;
      end
      if (state == ST_XFER)
        match_q <= op_q.cmp && (mem_rdata == acc_q);
      if (state == ST_UPD)
        cnt_nz_q <= (cnt_q != CNT_ONE);
    end
  end

  // R3: a write always follows the read of the same step
  a_r3_wr_after_rd: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> $past(mem_rd));
  // R4: search never writes
  a_r4_no_wr_search: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> !op_q.cmp);
  // R2: operands stay frozen while busy
  a_r2_op_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(op_q));
  // R8: a search hit ends the repeat
  a_r8_hit_stops: assert property (@(posedge clk) disable iff (rst)
    (state == ST_UPD && op_q.cmp && match_q) |=> done);
  // R10: done is a single pulse and the block then goes idle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));
endmodule

// File: rtl/blkop_seq.sv
module blkop_seq
  import blkop_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [AW-1:0] src_init,
  input  logic [AW-1:0] dst_init,
  input  logic [CW-1:0] cnt_init,
  input  logic [DW-1:0] acc,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          cnt_nz,
  output logic          match,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic [CW-1:0] count
);
  localparam int NPTR = 2;

  op_t    op_q;
  state_t state;
  logic   ld, step_src, step_dst, step_cnt;

  logic [AW-1:0] ptr_init [NPTR];
  logic [AW-1:0] ptr_q    [NPTR];
  logic          ptr_en   [NPTR];

  assign ptr_init[0] = src_init;
  assign ptr_init[1] = dst_init;
  assign ptr_en[0]   = step_src;
  assign ptr_en[1]   = step_dst;

  blkop_ctrl #(.CW(CW), .DW(DW)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .op_in(op), .acc_in(acc),
    .cnt_q(count), .mem_rdata(mem_rdata), .op_q(op_q), .state(state),
    .ld(ld), .step_src(step_src), .step_dst(step_dst), .step_cnt(step_cnt),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .busy(busy), .done(done),
    .match_q(match), .cnt_nz_q(cnt_nz)
  );

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    blkop_stepreg #(.W(AW)) ptr_i (
      .clk(clk), .rst(rst), .load(ld), .load_val(ptr_init[g]),
      .en(ptr_en[g]), .down(op_q.down), .q(ptr_q[g])
    );
  end

  blkop_stepreg #(.W(CW)) cnt_i (
    .clk(clk), .rst(rst), .load(ld), .load_val(cnt_init),
    .en(step_cnt), .down(1'b1), .q(count)
  );

  assign src_ptr   = ptr_q[0];
  assign dst_ptr   = ptr_q[1];
  assign mem_addr  = mem_wr ? dst_ptr : src_ptr;
  assign mem_wdata = mem_rdata;

  // R5: every register update takes exactly one off the count
  a_r5_cnt_dec: assert property (@(posedge clk) disable iff (rst)
    step_cnt |=> (count == $past(count) - CW'(1)));
  // R4: search leaves the destination pointer alone
  a_r4_dst_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && op_q.cmp && !ld) |=> $stable(dst_ptr));
  // R7: a repeating copy ends with a zero count
  a_r7_copy_zero: assert property (@(posedge clk) disable iff (rst)
    (done && op_q.rep && !op_q.cmp) |-> (count == '0 && !cnt_nz));
  // R9: the nonzero flag agrees with the count at completion
  a_r9_nz_flag: assert property (@(posedge clk) disable iff (rst)
    done |-> (cnt_nz == (count != '0)));
endmodule

// File: tb/blkop_seq_tb.sv
module blkop_seq_tb_top;
  localparam int AW = 8;
  localparam int CW = 4;
  localparam int DW = 8;
  localparam int NA = 1 << AW;
  localparam int NC = 1 << CW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2:0] op = '0;
  logic [AW-1:0] src_init = '0, dst_init = '0;
  logic [CW-1:0] cnt_init = '0;
  logic [DW-1:0] acc = '0;
  logic mem_rd, mem_wr, busy, done, cnt_nz, match;
  logic [AW-1:0] mem_addr, src_ptr, dst_ptr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [CW-1:0] count;

  always #10 clk = ~clk;

  blkop_seq #(.AW(AW), .CW(CW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .src_init(src_init),
    .dst_init(dst_init), .cnt_init(cnt_init), .acc(acc), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .cnt_nz(cnt_nz),
    .match(match), .src_ptr(src_ptr), .dst_ptr(dst_ptr), .count(count)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return DW'((i * 37 + 11) % 256);
  endfunction

  logic [DW-1:0] ram     [NA];
  logic [DW-1:0] exp_mem [NA];
  logic init_req = 1'b0;
  int   rd_cnt = 0;

  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < NA; i++) ram[i] <= pat(i);
      rd_cnt <= 0;
    end else begin
      if (mem_rd) begin
        mem_rdata <= ram[mem_addr];
        rd_cnt    <= rd_cnt + 1;
      end
      if (mem_wr) ram[mem_addr] <= mem_wdata;
    end
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] o, input int s, input int d,
                        input int c, input int a, input bit poke);
    int sm, dm, cm, steps, cyc, bad;
    bit m;
    logic [DW-1:0] b;
    @(negedge clk) init_req = 1'b1;
    @(negedge clk) init_req = 1'b0;
    for (int i = 0; i < NA; i++) exp_mem[i] = pat(i);
    sm = s; dm = d; cm = c; steps = 0; m = 1'b0;
    do begin
      b = exp_mem[sm];
      if (!o[1]) begin
        exp_mem[dm] = b;
        dm = o[0] ? (dm - 1) & (NA - 1) : (dm + 1) & (NA - 1);
      end else m = (b == DW'(a));
      sm = o[0] ? (sm - 1) & (NA - 1) : (sm + 1) & (NA - 1);
      cm = (cm - 1) & (NC - 1);
      steps++;
    end while (o[2] && cm != 0 && !(o[1] && m));

    op = o; src_init = AW'(s); dst_init = AW'(d); cnt_init = CW'(c); acc = DW'(a);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk("R10 busy after start", int'(busy), 1);
    cyc = 0;
    while (!done && cyc < 400) begin
      if (poke && cyc == 1) begin
        start = 1'b1; op = ~o; src_init = AW'(s + 64); cnt_init = CW'(c + 3);
      end else start = 1'b0;
      @(posedge clk); #1;
      cyc++;
    end
    start = 1'b0;
    chk("R10 cycles to done", cyc, 3 * steps);
    chk(poke ? "R2 steps with start while busy" :
        (!o[2] ? "R6 one-shot steps" : (o[1] ? "R8 search steps" : "R7 copy steps")),
        rd_cnt, steps);
    chk("R5 source pointer", int'(src_ptr), sm);
    chk(o[1] ? "R4 destination held" : "R5 destination pointer", int'(dst_ptr), dm);
    chk("R5 count", int'(count), cm);
    chk("R9 count nonzero", int'(cnt_nz), (cm != 0) ? 1 : 0);
    chk("R8 match", int'(match), (o[1] && m) ? 1 : 0);
    if (o[2] && !o[1]) chk("R7 nonzero flag clear", int'(cnt_nz), 0);
    bad = 0;
    for (int i = 0; i < NA; i++) if (ram[i] !== exp_mem[i]) bad++;
    chk(o[1] ? "R4 memory untouched" : "R3 memory after copy", bad, 0);
    @(posedge clk); #1;
    chk("R10 idle after done", int'(busy || done), 0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset mem strobes", int'(mem_rd || mem_wr), 0);
    chk("R1 reset flags", int'(cnt_nz || match), 0);
    @(negedge clk) rst = 1'b0;
    for (int o = 0; o < 8; o++) begin
      for (int c = 0; c < NC; c++) begin
        int s, d, k, a;
        s = o[0] ? 8'h05 : 8'hF8;
        d = o[0] ? 8'hC3 : 8'h40;
        k = ((c == 0) ? NC : c) / 2;
        if (c[0] == 1'b0) a = pat(o[0] ? (s - k) & (NA - 1) : (s + k) & (NA - 1));
        else              a = pat((s + 128) & (NA - 1));
        run_op(3'(o), s, d, c, a, 1'b0);
      end
    end
    run_op(3'b100, 8'h10, 8'h90, 6, 0, 1'b1);
    run_op(3'b110, 8'h20, 8'h90, 9, pat(8'h24), 1'b1);
    finish_run();
  end
endmodule